// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM channel. It owns the command pins from reset until the memory is ready. It first keeps the bus idle for the power-up interval. It then precharges every bank and issues two auto-refresh commands. After that it loads the mode register and then the extended mode register, and finally raises `init_done`. Every gap is derived from nanosecond parameters and the clock period: the count is the ceiling of the time divided by the period, and never less than one clock.

The two opcodes arrive as plain 11-bit control inputs. The block drives them onto the address pins during the cycle in which each load is issued. Bit 11 of the address tells the two loads apart: 0 selects the mode register and 1 selects the extended register. Bits the memory requires to be zero are forced to zero on the bus, whatever value the opcode input carries.

After `init_done` rises, the block drives NOP for as long as it stays out of reset. The normal request scheduler takes over from that point. There is no data stream, so no valid/ready interface is present.

Top module: `sdram_init_seq`

## Requirements
- R1: Let P = max(1, ceil(PWRUP_NS / CLK_NS)). For the P cycles that start with the reset state, every cycle shows NOP, address zero and `init_done` low. `cke` is high and every `dqm` bit is high in all cycles.
- R2: Command pins are {cs_n, ras_n, cas_n, we_n}. The encodings are NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001 and register load = 0000.
- R3: PRECHARGE is issued for one cycle at cycle P. Its address is 12'h400, which has only bit 10 set and so selects all banks.
- R4: With R = max(1, ceil(TRP_NS/CLK_NS)) and F = max(1, ceil(TRFC_NS/CLK_NS)), AUTO REFRESH is issued at cycle P+R and again at cycle P+R+F.
- R5: The mode-register load is issued at cycle P+R+2F. Its address has bit 11 = 0, and bits 10, 8 and 7 are forced to 0. Bit 9 and bits 6:0 are copied from `mode_op`.
- R6: With M = TMRD_CYC, the extended-register load is issued at cycle P+R+2F+M. Its address has bit 11 = 1, and bits 10:7 are forced to 0. Bits 6:0 are copied from `ext_op`: partial-refresh coverage in 2:0, temperature setting in 4:3 and drive strength in 6:5.
- R7: `init_done` rises at cycle P+R+2F+2M and stays high until reset. In those cycles the pins show NOP with address zero.
- R8: The command order is fixed and does not depend on the opcode values. Every cycle that is not one of the five command cycles shows NOP with address zero. A reset at any point restarts the sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_op | input | 11 | Opcode for the mode-register load |
| ext_op | input | 11 | Opcode for the extended-register load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| addr | output | 12 | Address pins; bit 11 selects the extended register |
| dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The embedded properties assume only that reset is applied before the first meaningful cycle. They place no constraint on the opcode inputs, which may hold any value, including ones in the reserved positions. The stimulus deliberately sets those reserved bits in one run and clears everything in another. It also asserts reset in the middle of the power-up wait to show that the sequence restarts. Each opcode is held steady within a run, so the bench model can predict the exact address value in every load cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int ADDR_W = 12;
  localparam int OP_W   = 11;

  // Opcode bits allowed through to the bus for each register load.
  localparam logic [OP_W-1:0] MODE_KEEP = 11'h27F;
  localparam logic [OP_W-1:0] EXT_KEEP  = 11'h07F;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LOAD
  } cmd_e;

  typedef enum logic [2:0] {
    STEP_WAIT,
    STEP_PRE,
    STEP_REF1,
    STEP_REF2,
    STEP_MRS,
    STEP_EMRS,
    STEP_DONE
  } step_e;

  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW = 4,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RST_VAL;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4: an expired interval never re-arms by itself
  assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CW       = 4,
  parameter int TRP_CYC  = 2,
  parameter int TRFC_CYC = 8,
  parameter int TMRD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expired,
  output logic          tload,
  output logic [CW-1:0] tval,
  output step_e         step,
  output logic          fresh,
  output logic          init_done
);

  localparam logic [CW-1:0] TRP_M1  = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] TRFC_M1 = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] TMRD_M1 = CW'(TMRD_CYC - 1);

  step_e step_nxt;

  always_comb begin
    step_nxt = step;
    tload    = 1'b0;
    tval     = '0;
    if (step != STEP_DONE && expired) begin
      step_nxt = step_e'(step + 3'd1);
      tload    = 1'b1;
      case (step_nxt)
        STEP_PRE:             tval = TRP_M1;
        STEP_REF1, STEP_REF2: tval = TRFC_M1;
        STEP_MRS, STEP_EMRS:  tval = TMRD_M1;
        default:              tval = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= STEP_WAIT;
      fresh <= 1'b0;
    end else begin
      step  <= step_nxt;
      fresh <= tload;
    end
  end

  assign init_done = (step == STEP_DONE);

  // R8: steps only ever advance by one
  assert_step_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step)) |-> (3'(step) == 3'($past(step) + 3'd1)));

  // R7: completion is sticky
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
(
  input  cmd_e cmd,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);

  always_comb begin
    cs_n = 1'b0;
    unique case (cmd)
      CMD_PRE:  {ras_n, cas_n, we_n} = 3'b010;
      CMD_REF:  {ras_n, cas_n, we_n} = 3'b001;
      CMD_LOAD: {ras_n, cas_n, we_n} = 3'b000;
      default:  {ras_n, cas_n, we_n} = 3'b111;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int PWRUP_NS = 100000,
  parameter int TRP_NS   = 18,
  parameter int TRFC_NS  = 80,
  parameter int TMRD_CYC = 2,
  parameter int DQM_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       mode_op,
  input  logic [10:0]       ext_op,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [11:0]       addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);

  localparam int PWR_CYC  = cycles_for(PWRUP_NS, CLK_NS);
  localparam int TRP_CYC  = cycles_for(TRP_NS, CLK_NS);
  localparam int TRFC_CYC = cycles_for(TRFC_NS, CLK_NS);
  localparam int MRD_CYC  = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
  localparam int MAX_A    = (PWR_CYC > TRFC_CYC) ? PWR_CYC : TRFC_CYC;
  localparam int MAX_B    = (TRP_CYC > MRD_CYC) ? TRP_CYC : MRD_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CW-1:0] PWR_M1 = CW'(PWR_CYC - 1);

  logic          expired;
  logic          tload;
  logic [CW-1:0] tval;
  step_e         step;
  logic          fresh;
  cmd_e          cmd;

  sdram_init_timer #(.CW(CW), .RST_VAL(PWR_M1)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tload),
    .load_val (tval),
    .expired  (expired)
  );

  sdram_init_fsm #(
    .CW       (CW),
    .TRP_CYC  (TRP_CYC),
    .TRFC_CYC (TRFC_CYC),
    .TMRD_CYC (MRD_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired   (expired),
    .tload     (tload),
    .tval      (tval),
    .step      (step),
    .fresh     (fresh),
    .init_done (init_done)
  );

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    if (fresh) begin
      case (step)
        STEP_PRE: begin
          cmd  = CMD_PRE;
          addr = 12'h400;
        end
        STEP_REF1, STEP_REF2: cmd = CMD_REF;
        STEP_MRS: begin
          cmd  = CMD_LOAD;
          addr = {1'b0, mode_op & MODE_KEEP};
        end
        STEP_EMRS: begin
          cmd  = CMD_LOAD;
          addr = {1'b1, ext_op & EXT_KEEP};
        end
        default: begin
          cmd  = CMD_NOP;
          addr = '0;
        end
      endcase
    end
  end

  sdram_init_cmd_enc enc_i (
    .cmd   (cmd),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n)
  );

  assign cke = 1'b1;
  assign dqm = {DQM_W{1'b1}};

  // R3: precharge always targets every bank
  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr == 12'h400));

  // R5: mode-register load keeps its reserved bits clear
  assert_mrs_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && !addr[11]) |->
      (!addr[10] && addr[8:7] == 2'b00));

  // R6: extended load keeps bits 10:7 clear
  assert_emrs_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && addr[11]) |->
      (addr[10:7] == 4'b0000));

  // R7: once finished, only NOP reaches the bus
  assert_done_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int CLK_NS = 10;
  localparam int DQM_W  = 2;

  function automatic int ceil_min1(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int P  = ceil_min1(100000);
  localparam int R  = ceil_min1(18);
  localparam int F  = ceil_min1(80);
  localparam int M  = 2;
  localparam int T_PRE  = P;
  localparam int T_REF1 = P + R;
  localparam int T_REF2 = P + R + F;
  localparam int T_MRS  = P + R + 2 * F;
  localparam int T_EMRS = T_MRS + M;
  localparam int T_DONE = T_EMRS + M;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [10:0]       mode_op = '0;
  logic [10:0]       ext_op = '0;
  logic              cs_n, ras_n, cas_n, we_n, cke, init_done;
  logic [11:0]       addr;
  logic [DQM_W-1:0]  dqm;

  int compared = 0;
  int mismatched = 0;
  int idx = 0;
  int ticks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_init_seq #(.CLK_NS(CLK_NS), .DQM_W(DQM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_op(mode_op), .ext_op(ext_op),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .addr(addr), .dqm(dqm), .init_done(init_done)
  );

  // Cycle index since the reset state (cycle 0 while in reset).
  always @(posedge clk) begin
    if (!rst_n) idx <= 0;
    else        idx <= idx + 1;
  end

  // R2 encodings: NOP 0111, PRE 0010, REF 0001, LOAD 0000
  function automatic logic [3:0] exp_pins(input int i);
    if (i == T_PRE) return 4'b0010;
    if (i == T_REF1 || i == T_REF2) return 4'b0001;
    if (i == T_MRS || i == T_EMRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [11:0] exp_addr(input int i);
    if (i == T_PRE) return 12'h400;
    if (i == T_MRS) return {1'b0, 1'b0, mode_op[9], 2'b00, mode_op[6:0]};
    if (i == T_EMRS) return {1'b1, 4'b0000, ext_op[6:0]};
    return 12'h000;
  endfunction

  function automatic string tag_of(input int i);
    if (i < P) return "R1";
    if (i == T_PRE) return "R3";
    if (i == T_REF1 || i == T_REF2) return "R4";
    if (i == T_MRS) return "R5";
    if (i == T_EMRS) return "R6";
    if (i >= T_DONE) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      logic [3:0] pins;
      pins = {cs_n, ras_n, cas_n, we_n};
      compared++;
      if (pins !== exp_pins(idx)) begin
        mismatched++;
        $display("FAIL R2 %s cycle %0d pins act=%b exp=%b", tag_of(idx), idx, pins, exp_pins(idx));
      end
      compared++;
      if (addr !== exp_addr(idx)) begin
        mismatched++;
        $display("FAIL %s cycle %0d addr act=%h exp=%h", tag_of(idx), idx, addr, exp_addr(idx));
      end
      compared++;
      if (init_done !== (idx >= T_DONE)) begin
        mismatched++;
        $display("FAIL R7 cycle %0d init_done act=%b exp=%b", idx, init_done, idx >= T_DONE);
      end
      compared++;
      if (cke !== 1'b1 || dqm !== {DQM_W{1'b1}}) begin
        mismatched++;
        $display("FAIL R1 cycle %0d cke/dqm act=%b/%b exp=1/%b", idx, cke, dqm, {DQM_W{1'b1}});
      end
    end
  end

  task automatic do_reset(input logic [10:0] m, input logic [10:0] e);
    @(negedge clk);
    rst_n = 1'b0;
    mode_op = m;
    ext_op = e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input int target);
    while (idx < target) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000 && !finished) begin
      mismatched++;
      $display("FAIL R7 watchdog expired at cycle %0d", idx);
      finish_run();
    end
  end

  initial begin
    // Run 1: reserved opcode bits all set (R5, R6 must clear them)
    do_reset(11'h7FF, 11'h7A5);
    run_to(T_DONE + 40);
    // Run 2: reset in the middle of the wait restarts the sequence (R8)
    do_reset(11'h032, 11'h000);
    run_to(P / 2);
    do_reset(11'h1C8, 11'h05A);
    run_to(T_DONE + 40);
    finish_run();
  end

endmodule